// File: doc/BRIEF.md
# Mode-Configurable Bidirectional Registered Transceiver

This block is the logical datapath of a byte-wide transceiver that joins two ports. The split port has its own input bus and its own output bus. The shared port is one common line group. It is modelled as an incoming value, an outgoing value and a per-bit active-low pull-down enable, as an open-collector bus would be. Data moving from the split port to the shared port passes through one storage stage. Data moving the other way passes through a second stage.

Each stage has its own two-bit mode field and its own strobe input. The mode selects an inverting pass-through, a register clocked by the rising edge of the strobe, or a latch that is transparent while the strobe is high. Every mode presents the complement of the incoming data. A loopback control feeds the split-port input into the shared-to-split stage and silences the shared-port drive. All storage is held in flops on the system clock. Strobe edges are detected at system clock edges.

Top module: `dual_mode_xcvr`

## Requirements
- R1: A synchronous active-high reset sets both stored values to all ones and clears both strobe-edge detectors. After reset, in the register mode, `a_out` reads 8'hFF and every bit of `b_drv_n` is 1 (released).
- R2: Mode 2'b00 is pass-through: the stage output equals the bitwise complement of its input in the same cycle.
- R3: Mode 2'b11 behaves exactly like mode 2'b00.
- R4: Mode 2'b01 is register mode. At a clock edge where the strobe is high and was low at the previous edge, the stage stores the complement of its input. The output shows the stored value from the next cycle and holds it at all other edges.
- R5: Mode 2'b10 is latch mode. While the strobe is high the output is the complement of the input, combinationally, and that value is stored at every clock edge with the strobe high. While the strobe is low the output shows the value stored at the last such edge.
- R6: The split-to-shared stage uses only `omode` and `stb_ab`. The shared-to-split stage uses only `imode` and `stb_ba`.
- R7: While `loopback` is 1, the shared-to-split stage takes `a_in` in place of `b_in`.
- R8: While `loopback` is 1, all bits of `b_drv_n` are 1.
- R9: `b_out` carries the split-to-shared stage output. Bit i of `b_drv_n` is 0 exactly when `drive_en` is 1, `loopback` is 0 and `b_out[i]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| omode | input | 2 | Mode of the split-to-shared stage |
| imode | input | 2 | Mode of the shared-to-split stage |
| stb_ab | input | 1 | Strobe or latch enable, split-to-shared |
| stb_ba | input | 1 | Strobe or latch enable, shared-to-split |
| loopback | input | 1 | Route split input into the shared-to-split stage |
| drive_en | input | 1 | Allows the shared-port pull-downs |
| a_in | input | 8 | Split-port input bus |
| a_out | output | 8 | Split-port output bus |
| b_in | input | 8 | Value seen on the shared bus |
| b_out | output | 8 | Value the shared port would present |
| b_drv_n | output | 8 | Per-bit pull-down enable, active low |

## Verification
The assertions assume that the modes, strobes, loopback and data are steady across each rising clock edge. Strobes are sampled only at clock edges, so a pulse between edges is treated as absent. The bench changes every input only on the falling clock edge, and it keeps each strobe high or low for at least one whole period. It sweeps all sixteen mode pairs with both loopback and both drive-enable settings. Pseudo-random data and strobe patterns fill each setting.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic [1:0] {
    XM_PASS     = 2'b00,
    XM_EDGE     = 2'b01,
    XM_LATCH    = 2'b10,
    XM_PASS_ALT = 2'b11
  } xmode_e;

  function automatic logic mode_is_edge(input logic [1:0] m);
    return m == XM_EDGE;
  endfunction

  function automatic logic mode_is_latch(input logic [1:0] m);
    return m == XM_LATCH;
  endfunction

  // Decides whether a stage stores a new value at this clock edge.
  function automatic logic stage_capture(input logic [1:0] m,
                                         input logic strobe,
                                         input logic strobe_prev);
    return (mode_is_edge(m) && strobe && !strobe_prev) ||
           (mode_is_latch(m) && strobe);
  endfunction

endpackage

// File: rtl/xcvr_stage.sv
module xcvr_stage
  import xcvr_pkg::*;
#(
  parameter int              W    = 8,
  parameter logic [W-1:0]    IDLE = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   mode,
  input  logic         strobe,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic [W-1:0] hold_o,
  output logic         rise_o
);

  logic [W-1:0] hold_q;
  logic         strobe_q;
  logic         cap;
  logic [W-1:0] inv_din;

  assign inv_din = ~din;
  assign rise_o  = strobe & ~strobe_q;
  assign cap     = stage_capture(mode, strobe, strobe_q);
  assign hold_o  = hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q   <= IDLE;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= strobe;
      if (cap) hold_q <= inv_din;
    end
  end

  always_comb begin
    unique case (mode)
      XM_EDGE:  dout = hold_q;
      XM_LATCH: dout = strobe ? inv_din : hold_q;
      default:  dout = inv_din;
    endcase
  end

endmodule

// File: rtl/oc_driver.sv
module oc_driver #(
  parameter int W = 8
) (
  input  logic         enable,
  input  logic [W-1:0] data,
  output logic [W-1:0] pull_n
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign pull_n[i] = ~(enable & ~data[i]);
  end

endmodule

// File: rtl/dual_mode_xcvr.sv
module dual_mode_xcvr
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   omode,
  input  logic [1:0]   imode,
  input  logic         stb_ab,
  input  logic         stb_ba,
  input  logic         loopback,
  input  logic         drive_en,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_drv_n
);

  localparam int NDIR   = 2;
  localparam int DIR_AB = 0;
  localparam int DIR_BA = 1;
  localparam logic [W-1:0] IDLE_VAL = '1;

  logic [W-1:0] st_din  [NDIR];
  logic [W-1:0] st_dout [NDIR];
  logic [W-1:0] st_hold [NDIR];
  logic [1:0]   st_mode [NDIR];
  logic         st_strb [NDIR];
  logic         st_rise [NDIR];

  // Named internal events for the checker.
  logic [W-1:0] ba_din;
  logic [W-1:0] ab_hold;
  logic [W-1:0] ba_hold;
  logic         ab_rise;
  logic         ba_rise;
  logic         oc_enable;

  assign ba_din = loopback ? a_in : b_in;

  assign st_din[DIR_AB]  = a_in;
  assign st_mode[DIR_AB] = omode;
  assign st_strb[DIR_AB] = stb_ab;
  assign st_din[DIR_BA]  = ba_din;
  assign st_mode[DIR_BA] = imode;
  assign st_strb[DIR_BA] = stb_ba;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    xcvr_stage #(.W(W), .IDLE(IDLE_VAL)) u_stage (
      .clk    (clk),
      .rst    (rst),
      .mode   (st_mode[d]),
      .strobe (st_strb[d]),
      .din    (st_din[d]),
      .dout   (st_dout[d]),
      .hold_o (st_hold[d]),
      .rise_o (st_rise[d])
    );
  end

  assign ab_hold = st_hold[DIR_AB];
  assign ba_hold = st_hold[DIR_BA];
  assign ab_rise = st_rise[DIR_AB];
  assign ba_rise = st_rise[DIR_BA];

  assign b_out     = st_dout[DIR_AB];
  assign a_out     = st_dout[DIR_BA];
  assign oc_enable = drive_en & ~loopback;

  oc_driver #(.W(W)) u_oc (
    .enable (oc_enable),
    .data   (b_out),
    .pull_n (b_drv_n)
  );

endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   omode,
  input logic [1:0]   imode,
  input logic         stb_ab,
  input logic         stb_ba,
  input logic         loopback,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] b_out,
  input logic [W-1:0] b_drv_n,
  input logic [W-1:0] ab_hold,
  input logic [W-1:0] ba_hold,
  input logic         ab_rise,
  input logic         ba_rise,
  input logic [W-1:0] ba_din
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (ab_hold == '1 && ba_hold == '1));

  assert_pass_ab_R2: assert property (@(posedge clk) disable iff (rst)
    (omode == 2'b00) |-> b_out == ~a_in);

  assert_pass_alt_ba_R3: assert property (@(posedge clk) disable iff (rst)
    (imode == 2'b11) |-> a_out == ~ba_din);

  assert_edge_capture_R4: assert property (@(posedge clk) disable iff (rst)
    (omode == 2'b01 && ab_rise) |=> ab_hold == ~$past(a_in));

  assert_edge_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (imode == 2'b01 && !ba_rise) |=> $stable(ba_hold));

  assert_latch_open_R5: assert property (@(posedge clk) disable iff (rst)
    (omode == 2'b10 && stb_ab) |-> b_out == ~a_in);

  assert_latch_closed_R5: assert property (@(posedge clk) disable iff (rst)
    (imode == 2'b10 && !stb_ba) |=> $stable(ba_hold));

  assert_loop_route_R7: assert property (@(posedge clk) disable iff (rst)
    (loopback && imode == 2'b00) |-> a_out == ~a_in);

  assert_loop_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    loopback |-> $countones(~b_drv_n) == 0);

  assert_oc_polarity_R9: assert property (@(posedge clk) disable iff (rst)
    (~b_drv_n & b_out) == '0);

endmodule

bind dual_mode_xcvr xcvr_checker #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .omode(omode), .imode(imode),
  .stb_ab(stb_ab), .stb_ba(stb_ba), .loopback(loopback),
  .a_in(a_in), .a_out(a_out), .b_out(b_out), .b_drv_n(b_drv_n),
  .ab_hold(ab_hold), .ba_hold(ba_hold), .ab_rise(ab_rise),
  .ba_rise(ba_rise), .ba_din(ba_din)
);

// File: tb/dual_mode_xcvr_test.sv
`timescale 1ns/1ps
module dual_mode_xcvr_test;

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] omode, imode;
  logic       stb_ab, stb_ba, loopback, drive_en;
  logic [7:0] a_in, b_in;
  logic [7:0] a_out, b_out, b_drv_n;

  int compared = 0;
  int mismatched = 0;
  bit reported = 0;

  // Bench-side reference state.
  logic [7:0] r_ab, r_ba;
  logic       p_ab, p_ba;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  dual_mode_xcvr uut (
    .clk(clk), .rst(rst), .omode(omode), .imode(imode),
    .stb_ab(stb_ab), .stb_ba(stb_ba), .loopback(loopback),
    .drive_en(drive_en), .a_in(a_in), .a_out(a_out),
    .b_in(b_in), .b_out(b_out), .b_drv_n(b_drv_n)
  );

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    end
  endtask

  task automatic check(input string tag, input string what,
                       input logic [7:0] got, input logic [7:0] want);
    compared++;
    if (got !== want) begin
      mismatched++;
      $display("FAIL %s %s: got %02h expected %02h (om=%0d im=%0d lb=%0b de=%0b)",
               tag, what, got, want, omode, imode, loopback, drive_en);
    end
  endtask

  function automatic logic [7:0] view(input logic [1:0] m, input logic en,
                                      input logic [7:0] d, input logic [7:0] h);
    if (m == 2'd1) return h;
    if (m == 2'd2) return en ? 8'hFF ^ d : h;
    return 8'hFF ^ d;
  endfunction

  function automatic string tag_of(input logic [1:0] m);
    case (m)
      2'd0: return "R2";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R3";
    endcase
  endfunction

  // Reference update at each rising edge, from the inputs driven beforehand.
  task automatic ref_edge();
    logic [7:0] src;
    src = loopback ? a_in : b_in;
    if (rst) begin
      r_ab = 8'hFF; r_ba = 8'hFF; p_ab = 0; p_ba = 0;
    end else begin
      if ((omode == 2'd1 && stb_ab && !p_ab) || (omode == 2'd2 && stb_ab)) r_ab = 8'hFF ^ a_in;
      if ((imode == 2'd1 && stb_ba && !p_ba) || (imode == 2'd2 && stb_ba)) r_ba = 8'hFF ^ src;
      p_ab = stb_ab; p_ba = stb_ba;
    end
  endtask

  task automatic compare_all();
    logic [7:0] src, eb, ea, edrv;
    string ta;
    src  = loopback ? a_in : b_in;
    eb   = view(omode, stb_ab, a_in, r_ab);
    ea   = view(imode, stb_ba, src, r_ba);
    edrv = 8'hFF ^ ({8{drive_en & ~loopback}} & (8'hFF ^ eb));
    ta   = loopback ? "R7" : tag_of(imode);
    check(ta, "a_out", a_out, ea);
    check({tag_of(omode), "/R6"}, "b_out", b_out, eb);
    check(loopback ? "R8" : "R9", "b_drv_n", b_drv_n, edrv);
  endtask

  task automatic cycle();
    @(posedge clk);
    ref_edge();
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    mismatched++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    report();
    $finish;
  end

  initial begin
    rst = 1; omode = 2'd1; imode = 2'd1; stb_ab = 0; stb_ba = 0;
    loopback = 0; drive_en = 1; a_in = 8'h5A; b_in = 8'hC3;
    r_ab = 'x; r_ba = 'x; p_ab = 0; p_ba = 0;
    @(negedge clk);
    repeat (3) cycle();
    rst = 0;
    #1;
    // R1: reset state seen at the ports in register mode
    check("R1", "a_out", a_out, 8'hFF);
    check("R1", "b_drv_n", b_drv_n, 8'hFF);
    @(negedge clk);

    for (int om = 0; om < 4; om++)
      for (int im = 0; im < 4; im++)
        for (int lb = 0; lb < 2; lb++)
          for (int de = 0; de < 2; de++) begin
            omode = om[1:0]; imode = im[1:0];
            loopback = lb[0]; drive_en = de[0];
            for (int k = 0; k < 20; k++) begin
              lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
              a_in = lfsr[7:0];
              b_in = lfsr[15:8] ^ 8'h3C;
              stb_ab = lfsr[3] ^ lfsr[9];
              stb_ba = lfsr[5] ^ lfsr[14];
              #1;
              compare_all();
              cycle();
            end
          end

    // R1: reset again mid-run with latch modes, strobes low
    omode = 2'd2; imode = 2'd2; stb_ab = 0; stb_ba = 0; loopback = 0;
    rst = 1;
    cycle();
    rst = 0;
    #1;
    check("R1", "a_out latch hold", a_out, 8'hFF);
    check("R1", "b_out latch hold", b_out, 8'hFF);

    report();
    $finish;
  end

endmodule